// File: doc/BRIEF.md
# Fan PWM Spin-up Controller

This block runs the start-up phase of three fan PWM channels. A start request on a channel forces that channel's duty output to full scale for a spin-up interval. When the interval ends, the channel hands its duty output back to the normal duty value supplied from outside. The interval length comes from a 3-bit duration code per channel. The code selects a number of ticks from a prescaled time base, and code 0 means the channel skips spin-up.

Each channel has one termination-mode bit. With the bit clear, spin-up lasts for the full programmed interval. With the bit set, spin-up also ends early. This happens when a freshly flagged tachometer measurement is strictly above the tach-minimum value for that channel, if that comes before the timer runs out. The mode bits sit in the low three bits of an 8-bit mode value, and their reset value is 07h. While the global enable input is low, every channel acts as if its mode bit were 1, whatever value has been written.

Top module: `fan_spinup_ctrl`

## Requirements
- R1: After reset, `spin_active` is 0 on all channels and each `duty_out` lane equals its `duty_in` lane.
- R2: A `spin_req` pulse on a channel with a nonzero duration code sets that channel's `spin_active` in the next cycle. While `spin_active` is set, that channel's `duty_out` lane reads FFh.
- R3: A `spin_req` pulse on a channel whose duration code is 0 leaves that channel's `spin_active` at 0.
- R4: Code c (1..7) selects L = TICK_BASE << (c-1) ticks of PRESCALE cycles each. In fixed mode, spin-up stays active for between (L-1)*PRESCALE+1 and L*PRESCALE cycles.
- R5: In early mode, a cycle with `tach_valid` set and `tach_val` strictly greater than `tach_min` ends spin-up in the next cycle. A reading equal to the minimum does not end it.
- R6: A tach reading above the minimum with `tach_valid` low has no effect on spin-up.
- R7: With the channel's mode bit at 0 and `start_en` high, valid tach readings above the minimum do not shorten spin-up.
- R8: Mode bit n of the mode value (bits 2..0 for channels 2..0; bits 7..3 ignored) is written by `mode_we`. Its reset value is 07h. While `start_en` is 0, all channels use early mode regardless of the written value.
- R9: A `spin_req` during spin-up restarts the timer from zero. It wins over an early-termination event in the same cycle.
- R10: Channels are independent. Activity on one channel never changes another channel's `spin_active` or `duty_out`.
- R11: When a channel is not in spin-up, its `duty_out` lane equals its `duty_in` lane in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_en | input | 1 | Global enable; when low, all channels use early mode |
| mode_we | input | 1 | Write strobe for the mode value |
| mode_wdata | input | 8 | Mode value; bit n selects the mode of channel n |
| spin_req | input | 3 | Per-channel spin-up start pulse |
| dur_code | input | 9 | 3-bit duration code per channel |
| tach_val | input | 48 | 16-bit tach reading per channel |
| tach_valid | input | 3 | Per-channel flag: new tach reading this cycle |
| tach_min | input | 48 | 16-bit tach-minimum threshold per channel |
| duty_in | input | 24 | 8-bit normal duty per channel |
| spin_active | output | 3 | Per-channel spin-up active flag |
| duty_out | output | 24 | 8-bit duty per channel after the override |

## Verification
Two events can land in the same cycle: a new start request and a qualifying early-termination reading. The bench provokes this during an active spin-up by raising `spin_req` and a valid above-threshold tach reading on the same edge. It passes only if the channel stays active and a full new interval follows. A second coincidence is the timer's final tick landing on the same edge as a valid reading. Either event ends the spin-up at that edge, so the bench judges this case by the measured duration, which must stay inside the window set by R4.

// File: rtl/fan_spinup_pkg.sv
// Shared constants and helpers for the fan spin-up controller.
// Assumes 3-bit duration codes; code 0 means no spin-up.
package fan_spinup_pkg;
    localparam int CODE_W = 3;
    localparam int DUTY_FULL = 255;

    // Number of ticks selected by a duration code.
    function automatic int unsigned code_ticks(input logic [CODE_W-1:0] code,
                                               input int unsigned base);
        if (code == '0) return 0;
        return base << (code - 1);
    endfunction
endpackage

// File: rtl/spin_tick_gen.sv
// Free-running prescaler: emits one-cycle tick every PRESCALE cycles.
// Assumes PRESCALE >= 2.
module spin_tick_gen #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(PRESCALE);

    logic [PW-1:0] pcnt;

    // Count cycles modulo PRESCALE.
    always_ff @(posedge clk) begin
        if (!rst_n) pcnt <= '0;
        else if (pcnt == PW'(PRESCALE - 1)) pcnt <= '0;
        else pcnt <= pcnt + 1'b1;
    end

    assign tick = (pcnt == PW'(PRESCALE - 1));

    // R4: ticks are isolated pulses
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spin_mode_reg.sv
// Holds the per-channel termination-mode bits (reset all ones) and
// produces the effective mode: all ones while the global enable is low.
// Upper written bits beyond NUM_CH are dropped.
module spin_mode_reg #(
    parameter int NUM_CH = 3,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_en,
    input  logic              mode_we,
    input  logic [REG_W-1:0]  mode_wdata,
    output logic [NUM_CH-1:0] mode_eff
);
    logic [NUM_CH-1:0] mode_q;

    // Store the mode bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '1;
        else if (mode_we) mode_q <= mode_wdata[NUM_CH-1:0];
    end

    // Substitute the default while the global enable is low.
    always_comb mode_eff = start_en ? mode_q : '1;

    // R8: stored value follows a write
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> mode_q == $past(mode_wdata[NUM_CH-1:0]));
endmodule

// File: rtl/spin_channel.sv
// One spin-up channel: latches the tick limit on a start request,
// counts prescaled ticks, and ends on timer expiry or (early mode)
// on a valid tach reading above the minimum. A request always restarts.
module spin_channel
    import fan_spinup_pkg::*;
#(
    parameter int TACH_W    = 16,
    parameter int TICK_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              early_mode,
    input  logic              req,
    input  logic [CODE_W-1:0] code,
    input  logic [TACH_W-1:0] tach_val,
    input  logic              tach_valid,
    input  logic [TACH_W-1:0] tach_min,
    output logic              active
);
    localparam int MAX_TICKS = TICK_BASE << ((1 << CODE_W) - 2);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             timer_done;
    logic             early_hit;

    // Termination conditions for this cycle.
    always_comb begin
        timer_done = tick && ((cnt + 1'b1) == lim);
        early_hit  = early_mode && tach_valid && (tach_val > tach_min);
    end

    // Spin-up state: start/restart, count, terminate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            lim    <= '0;
        end else if (req) begin
            active <= (code != '0);
            cnt    <= '0;
            lim    <= CNT_W'(code_ticks(code, TICK_BASE));
        end else if (active) begin
            if (timer_done || early_hit) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && code != '0) |=> active);
    // R3
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && code == '0) |=> !active);
    // R5
    early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !req && early_hit) |=> !active);
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt < lim);
    // R6
    stale_tach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !req && !tach_valid && !timer_done) |=> active);
endmodule

// File: rtl/fan_spinup_ctrl.sv
// Top of the fan spin-up controller: shared prescaler, mode register,
// and one spin_channel per fan. Forces full duty while a channel spins up.
module fan_spinup_ctrl
    import fan_spinup_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int TACH_W    = 16,
    parameter int DUTY_W    = 8,
    parameter int REG_W     = 8,
    parameter int PRESCALE  = 4,
    parameter int TICK_BASE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_en,
    input  logic                     mode_we,
    input  logic [REG_W-1:0]         mode_wdata,
    input  logic [NUM_CH-1:0]        spin_req,
    input  logic [NUM_CH*CODE_W-1:0] dur_code,
    input  logic [NUM_CH*TACH_W-1:0] tach_val,
    input  logic [NUM_CH-1:0]        tach_valid,
    input  logic [NUM_CH*TACH_W-1:0] tach_min,
    input  logic [NUM_CH*DUTY_W-1:0] duty_in,
    output logic [NUM_CH-1:0]        spin_active,
    output logic [NUM_CH*DUTY_W-1:0] duty_out
);
    logic              tick;
    logic [NUM_CH-1:0] mode_eff;

    spin_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    spin_mode_reg #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .start_en(start_en),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_eff(mode_eff)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        spin_channel #(.TACH_W(TACH_W), .TICK_BASE(TICK_BASE)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .early_mode(mode_eff[g]),
            .req(spin_req[g]),
            .code(dur_code[g*CODE_W +: CODE_W]),
            .tach_val(tach_val[g*TACH_W +: TACH_W]),
            .tach_valid(tach_valid[g]),
            .tach_min(tach_min[g*TACH_W +: TACH_W]),
            .active(spin_active[g])
        );

        // Duty override mux for this channel.
        always_comb duty_out[g*DUTY_W +: DUTY_W] =
            spin_active[g] ? '1 : duty_in[g*DUTY_W +: DUTY_W];
    end
endmodule

// File: tb/sim_fan_spinup_ctrl.sv
// Bench: directed corner cases plus seeded random fixed-mode runs.
module sim_fan_spinup_ctrl;
    localparam int NCH = 3, TW = 16, DW = 8, P = 4, BASE = 2;

    logic clk = 0, rst_n = 0, start_en = 0, mode_we = 0;
    logic [7:0] mode_wdata = 0;
    logic [NCH-1:0] spin_req = 0, tach_valid = 0;
    logic [NCH*3-1:0] dur_code = 0;
    logic [NCH*TW-1:0] tach_val = 0, tach_min = 0;
    logic [NCH*DW-1:0] duty_in = 0;
    logic [NCH-1:0] spin_active;
    logic [NCH*DW-1:0] duty_out;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    fan_spinup_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_en(start_en), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .spin_req(spin_req), .dur_code(dur_code),
        .tach_val(tach_val), .tach_valid(tach_valid), .tach_min(tach_min),
        .duty_in(duty_in), .spin_active(spin_active), .duty_out(duty_out)
    );

    function automatic int ticks_of(input int code);
        return BASE << (code - 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk); mode_we = 1; mode_wdata = v;
        @(negedge clk); mode_we = 0;
    endtask

    // Pulse a start request, return the number of active cycles.
    task automatic measure(input int ch, input int code, output int cyc);
        @(negedge clk);
        dur_code[ch*3 +: 3] = 3'(code);
        spin_req[ch] = 1;
        @(negedge clk);
        spin_req[ch] = 0;
        cyc = 0;
        while (spin_active[ch] && cyc < 2000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle(input int ch);
        for (int i = 0; i < 2000 && spin_active[ch]; i++) @(negedge clk);
    endtask

    task automatic pulse_tach(input int ch, input int val, input bit vld);
        tach_val[ch*TW +: TW] = 16'(val);
        tach_valid[ch] = vld;
        @(negedge clk);
        tach_valid[ch] = 0;
        tach_val[ch*TW +: TW] = 0;
    endtask

    task automatic start_only(input int ch, input int code);
        @(negedge clk);
        dur_code[ch*3 +: 3] = 3'(code);
        spin_req[ch] = 1;
        @(negedge clk);
        spin_req[ch] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc, lo, hi;
        void'($urandom(32'd4242));
        duty_in = {8'h30, 8'h50, 8'h70};
        tach_min = {16'd1000, 16'd1000, 16'd1000};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(spin_active == 0, "R1 active after reset", spin_active, 0);
        chk(duty_out == duty_in, "R1 duty after reset", duty_out, duty_in);

        // R2, R10, R11: channel 1 spins, others pass through
        start_only(1, 3);
        chk(spin_active == 3'b010, "R2/R10 active flag", spin_active, 3'b010);
        chk(duty_out[15:8] == 8'hFF, "R2 forced duty", duty_out[15:8], 255);
        chk(duty_out[7:0] == 8'h70 && duty_out[23:16] == 8'h30, "R10 other lanes",
            duty_out[7:0], 8'h70);
        duty_in[7:0] = 8'h11;
        #1 chk(duty_out[7:0] == 8'h11, "R11 same-cycle passthrough", duty_out[7:0], 8'h11);
        wait_idle(1);
        chk(duty_out[15:8] == 8'h50, "R11 duty after spin-up", duty_out[15:8], 8'h50);

        // R3: code 0
        start_only(2, 0);
        chk(spin_active[2] == 0, "R3 zero code", spin_active[2], 0);

        // R8: reset mode 07h with start_en high -> early mode
        start_en = 1;
        start_only(0, 7);
        repeat (3) @(negedge clk);
        pulse_tach(0, 1001, 1);
        chk(spin_active[0] == 0, "R8 reset mode early", spin_active[0], 0);

        // R5: equal reading does not end; above ends
        start_only(0, 7);
        pulse_tach(0, 1000, 1);
        chk(spin_active[0] == 1, "R5 equal reading", spin_active[0], 1);
        // R6: above but not valid
        pulse_tach(0, 5000, 0);
        chk(spin_active[0] == 1, "R6 stale reading", spin_active[0], 1);
        pulse_tach(0, 1001, 1);
        chk(spin_active[0] == 0, "R5 above reading ends", spin_active[0], 0);

        // R7: fixed mode on ch0, tach ignored, full duration kept
        write_mode(8'hFE);
        start_only(0, 2);
        pulse_tach(0, 9000, 1);
        chk(spin_active[0] == 1, "R7 fixed ignores tach", spin_active[0], 1);
        wait_idle(0);
        measure(0, 2, cyc);
        lo = (ticks_of(2) - 1) * P + 1; hi = ticks_of(2) * P;
        chk(cyc >= lo && cyc <= hi, "R4 fixed duration code2", cyc, lo);

        // R8: start_en low overrides written fixed mode
        start_en = 0;
        start_only(0, 7);
        pulse_tach(0, 2000, 1);
        chk(spin_active[0] == 0, "R8 default while disabled", spin_active[0], 0);
        start_en = 1;

        // R9: restart and same-cycle request wins over early end (ch1 early mode)
        start_only(1, 1);
        @(negedge clk);
        tach_val[TW +: TW] = 16'd4000;
        tach_valid[1] = 1;
        dur_code[5:3] = 3'd1;
        spin_req[1] = 1;
        @(negedge clk);
        spin_req[1] = 0; tach_valid[1] = 0; tach_val[TW +: TW] = 0;
        chk(spin_active[1] == 1, "R9 request beats early end", spin_active[1], 1);
        cyc = 1;
        while (spin_active[1] && cyc < 2000) begin cyc++; @(negedge clk); end
        lo = (ticks_of(1) - 1) * P + 1; hi = ticks_of(1) * P;
        chk(cyc >= lo && cyc <= hi, "R9 restarted duration", cyc, lo);

        // R4: random fixed-mode runs
        write_mode(8'h00);
        for (int i = 0; i < 20; i++) begin
            int ch = int'($urandom_range(0, NCH - 1));
            int code = int'($urandom_range(1, 5));
            measure(ch, code, cyc);
            lo = (ticks_of(code) - 1) * P + 1; hi = ticks_of(code) * P;
            chk(cyc >= lo && cyc <= hi, "R4 random fixed duration", cyc, lo);
            chk(duty_out == duty_in, "R11 idle duty", duty_out, duty_in);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule